// File: doc/BRIEF.md
# Processor Status Flag Generator

This block turns the outcome of one ALU operation into the arithmetic status flags of a processor and keeps them, together with three stored control flags, in a single flag register. For each accepted operation it sees both operands, the result, a carry/borrow vector with one bit per operand size, an operation class and an operand size of 8, 16 or 32 bits. Carry, parity, half-carry, zero, sign and overflow are recomputed or held depending on the operation class. The trap, interrupt-enable and direction flags are never computed. They change only through a separate write port.

Operations arrive on a valid/ready stream. The block takes one operation per cycle and never applies back-pressure. `in_ready` is low while reset is held and high from the first clock after reset is released. An operation is accepted on a rising edge where both `in_valid` and `in_ready` are high. The flag register shows its effect from that edge on. The control-flag write port is a plain strobe. It does not depend on the stream and may coincide with an accepted operation.

Flag register layout (`flags`): bit 0 carry, bit 1 parity, bit 2 half-carry, bit 3 zero, bit 4 sign, bit 5 overflow, bit 6 trap, bit 7 interrupt-enable, bit 8 direction.

Top module: `status_flag_gen`

## Requirements
- R1: While `rst_n` is low, every bit of `flags` is cleared and `in_ready` is low. `in_ready` is high on every cycle after the first rising edge with `rst_n` high.
- R2: For add (class 0) and subtract (class 1), carry takes `carry_out[k]`, where k is the lane of the active size. Bit k holds the carry out of the top bit of that lane for an add, or the borrow for a subtract.
- R3: For classes 0, 1 and 2, parity is 1 when `result[7:0]` holds an even number of ones, including none, and 0 when the count is odd. This holds at every operand size.
- R4: For add and subtract, half-carry equals `opnd_a[4] ^ opnd_b[4] ^ result[4]`, which is the carry or borrow between bits 3 and 4.
- R5: For classes 0, 1 and 2, zero is 1 exactly when the result bits of the active size are all zero. Bits above the active size are ignored.
- R6: For classes 0, 1 and 2, sign copies the top result bit of the active size (bit 7, 15 or 31).
- R7: Overflow is set on an add when both operands share a sign and the result's sign differs from it. It is set on a subtract when the operand signs differ and the result's sign differs from that of `opnd_a`. The signs are taken at the active size.
- R8: A logic operation (class 2) clears carry and overflow and leaves half-carry unchanged.
- R9: A data move (class 3), a control transfer (class 4) and class codes 5 to 7 leave all six arithmetic flags unchanged.
- R10: The control flags (bits 8:6) are loaded from `ctl_wdata` on a rising edge with `ctl_we` high. Nothing else changes them, and a simultaneous operation still updates the arithmetic flags.
- R11: On a cycle with `in_valid` low and `ctl_we` low, `flags` holds its value.
- R12: `op_size` encodes 0 as 8 bits, 1 as 16 bits and 2 as 32 bits. Code 3 behaves as 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present on the stream |
| in_ready | output | 1 | Block accepts an operation (high after reset) |
| op_class | input | 3 | 0 add, 1 subtract, 2 logic, 3 move, 4 control transfer |
| op_size | input | 2 | Operand size: 0 = 8, 1 = 16, 2 or 3 = 32 bits |
| opnd_a | input | 32 | First operand (minuend on subtract) |
| opnd_b | input | 32 | Second operand (subtrahend on subtract) |
| result | input | 32 | ALU result |
| carry_out | input | 3 | Carry/borrow out of the 8-, 16- and 32-bit lanes (bits 0, 1, 2) |
| ctl_we | input | 1 | Write strobe for the control flags |
| ctl_wdata | input | 3 | New trap, interrupt-enable, direction values (bits 0, 1, 2) |
| flags | output | 9 | Flag register, layout as above |

## Verification
The assertions assume that the stream inputs are driven to known values whenever `in_valid` is high, and that `in_valid` stays low while reset is held. The flag rules themselves accept any combination of operands, result and carry vector. The stimulus drives inputs only away from the clock edge and holds `in_valid` low through reset. For add and subtract it builds the result and the per-lane carry/borrow vector from the operands, so the arithmetic flags get consistent values. For the other classes it draws results and carry bits at random, which exercises every class and size code, including the undefined ones.

// File: rtl/sfg_pkg.sv
package sfg_pkg;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_LOGIC = 3'd2,
    OPC_MOVE  = 3'd3,
    OPC_CTRL  = 3'd4
  } op_class_e;

  localparam int ARITH_W = 6;
  localparam int CTL_W   = 3;
  localparam int FLAG_W  = ARITH_W + CTL_W;

  // packed with carry in bit 0, overflow in bit 5
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic hcy;
    logic par;
    logic cry;
  } arith_flags_t;

endpackage

// File: rtl/sfg_size_slice.sv
module sfg_size_slice #(
  parameter int DATA_W    = 32,
  parameter int NUM_SIZES = 3,
  parameter int SEL_W     = 2
) (
  input  logic [SEL_W-1:0]     size_sel,
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic [DATA_W-1:0]    r_i,
  input  logic [NUM_SIZES-1:0] cout_vec,
  output logic                 a_msb,
  output logic                 b_msb,
  output logic                 r_msb,
  output logic                 r_zero,
  output logic                 cout_sel
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(NUM_SIZES - 1);

  logic [NUM_SIZES-1:0] a_top, b_top, r_top, z_lane;
  logic [SEL_W-1:0]     lane;

  for (genvar k = 0; k < NUM_SIZES; k++) begin : g_lane
    localparam int LW = 8 << k;
    assign a_top[k]  = a_i[LW-1];
    assign b_top[k]  = b_i[LW-1];
    assign r_top[k]  = r_i[LW-1];
    assign z_lane[k] = ~|r_i[LW-1:0];
  end

  // unused size codes fall back to the widest lane
  assign lane     = (size_sel > LAST) ? LAST : size_sel;
  assign a_msb    = a_top[lane];
  assign b_msb    = b_top[lane];
  assign r_msb    = r_top[lane];
  assign r_zero   = z_lane[lane];
  assign cout_sel = cout_vec[lane];
endmodule

// File: rtl/sfg_arith_calc.sv
module sfg_arith_calc
  import sfg_pkg::*;
(
  input  logic [2:0]   op_class,
  input  logic         a_msb,
  input  logic         b_msb,
  input  logic         r_msb,
  input  logic         r_zero,
  input  logic         cout_sel,
  input  logic         a_b4,
  input  logic         b_b4,
  input  logic         r_b4,
  input  logic [7:0]   r_low,
  input  arith_flags_t prev,
  output arith_flags_t next,
  output logic         load
);
  always_comb begin
    next     = prev;
    load     = 1'b0;
    next.par = ~^r_low;
    next.zro = r_zero;
    next.sgn = r_msb;
    case (op_class)
      OPC_ADD: begin
        load     = 1'b1;
        next.cry = cout_sel;
        next.hcy = a_b4 ^ b_b4 ^ r_b4;
        next.ovf = (a_msb == b_msb) && (r_msb != a_msb);
      end
      OPC_SUB: begin
        load     = 1'b1;
        next.cry = cout_sel;
        next.hcy = a_b4 ^ b_b4 ^ r_b4;
        next.ovf = (a_msb != b_msb) && (r_msb != a_msb);
      end
      OPC_LOGIC: begin
        load     = 1'b1;
        next.cry = 1'b0;
        next.ovf = 1'b0;
      end
      default: load = 1'b0;
    endcase
  end
endmodule

// File: rtl/sfg_flag_reg.sv
module sfg_flag_reg
  import sfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arith_we,
  input  arith_flags_t      arith_d,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_d,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      if (arith_we) flags_q[ARITH_W-1:0] <= arith_d;
      if (ctl_we)   flags_q[FLAG_W-1:ARITH_W] <= ctl_d;
    end
  end

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!arith_we && !ctl_we) |=> $stable(flags_q));

  assert_ctl_only_by_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(flags_q[FLAG_W-1:ARITH_W]));

  assert_ctl_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> flags_q[FLAG_W-1:ARITH_W] == $past(ctl_d));
endmodule

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import sfg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_SIZES = 3,
  parameter int SEL_W     = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2:0]           op_class,
  input  logic [SEL_W-1:0]     op_size,
  input  logic [DATA_W-1:0]    opnd_a,
  input  logic [DATA_W-1:0]    opnd_b,
  input  logic [DATA_W-1:0]    result,
  input  logic [NUM_SIZES-1:0] carry_out,
  input  logic                 ctl_we,
  input  logic [CTL_W-1:0]     ctl_wdata,
  output logic [FLAG_W-1:0]    flags
);
  logic         ready_q;
  logic         a_msb, b_msb, r_msb, r_zero, cout_sel;
  logic         calc_load, accept;
  arith_flags_t cur_arith, nxt_arith;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end
  assign in_ready  = ready_q;
  assign accept    = in_valid && ready_q;
  assign cur_arith = arith_flags_t'(flags[ARITH_W-1:0]);

  sfg_size_slice #(.DATA_W(DATA_W), .NUM_SIZES(NUM_SIZES), .SEL_W(SEL_W)) u_slice (
    .size_sel (op_size),
    .a_i      (opnd_a),
    .b_i      (opnd_b),
    .r_i      (result),
    .cout_vec (carry_out),
    .a_msb    (a_msb),
    .b_msb    (b_msb),
    .r_msb    (r_msb),
    .r_zero   (r_zero),
    .cout_sel (cout_sel)
  );

  sfg_arith_calc u_calc (
    .op_class (op_class),
    .a_msb    (a_msb),
    .b_msb    (b_msb),
    .r_msb    (r_msb),
    .r_zero   (r_zero),
    .cout_sel (cout_sel),
    .a_b4     (opnd_a[4]),
    .b_b4     (opnd_b[4]),
    .r_b4     (result[4]),
    .r_low    (result[7:0]),
    .prev     (cur_arith),
    .next     (nxt_arith),
    .load     (calc_load)
  );

  sfg_flag_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .arith_we (accept && calc_load),
    .arith_d  (nxt_arith),
    .ctl_we   (ctl_we),
    .ctl_d    (ctl_wdata),
    .flags_q  (flags)
  );

  assert_parity_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_class <= 3'd2) |=> flags[1] == ~^$past(result[7:0]));

  assert_sign_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_class <= 3'd2 && op_size == '0) |=> flags[4] == $past(result[7]));

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_class == 3'd2) |=> (!flags[0] && !flags[5] && $stable(flags[2])));

  assert_move_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && op_class >= 3'd3) |=> $stable(flags[ARITH_W-1:0]));

  assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

// File: tb/status_flag_gen_tb_top.sv
module status_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  op_class = '0;
  logic [1:0]  op_size = '0;
  logic [31:0] opnd_a = '0, opnd_b = '0, result = '0;
  logic [2:0]  carry_out = '0;
  logic        ctl_we = 1'b0;
  logic [2:0]  ctl_wdata = '0;
  logic [8:0]  flags;
  logic [8:0]  exp_f = '0;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  status_flag_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_class(op_class), .op_size(op_size), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .result(result), .carry_out(carry_out), .ctl_we(ctl_we),
    .ctl_wdata(ctl_wdata), .flags(flags)
  );

  function automatic string field_req(int i);
    case (i)
      0: return "R2 carry";
      1: return "R3 parity";
      2: return "R4 half-carry";
      3: return "R5 zero";
      4: return "R6 sign";
      5: return "R7 overflow";
      default: return "R10 control";
    endcase
  endfunction

  function automatic logic [8:0] model(input logic [8:0] p, input logic v,
      input logic [2:0] c, input logic [1:0] s, input logic [31:0] a, b, r,
      input logic [2:0] cv, input logic cwe, input logic [2:0] cwd);
    logic [8:0] n = p;
    int idx = (s == 2'd3) ? 2 : int'(s);   // R12
    int top = (8 << idx) - 1;
    if (v && c <= 3'd2) begin
      n[1] = ~^r[7:0];
      n[3] = ((r << (31 - top)) == 32'd0);
      n[4] = r[top];
      if (c == 3'd2) begin
        n[0] = 1'b0; n[5] = 1'b0;
      end else begin
        n[0] = cv[idx];
        n[2] = a[4] ^ b[4] ^ r[4];
        if (c == 3'd0) n[5] = (a[top] == b[top]) && (r[top] != a[top]);
        else           n[5] = (a[top] != b[top]) && (r[top] != a[top]);
      end
    end
    if (cwe) n[8:6] = cwd;
    return n;
  endfunction

  function automatic logic [2:0] lane_carries(input logic [2:0] c, input logic [31:0] a, b);
    logic [2:0] cv;
    for (int k = 0; k < 3; k++) begin
      logic [32:0] m = (33'd1 << (8 << k)) - 33'd1;
      logic [32:0] am = {1'b0, a} & m;
      logic [32:0] bm = {1'b0, b} & m;
      logic [32:0] sum = am + bm;
      if (c == 3'd0) cv[k] = sum[8 << k];
      else           cv[k] = (am < bm);
    end
    return cv;
  endfunction

  task automatic compare(input string ctx);
    checks++;
    if (flags !== exp_f) begin
      errors++;
      for (int i = 0; i < 9; i++)
        if (flags[i] !== exp_f[i])
          $display("FAIL %s (%s): flags=%h expected=%h", field_req(i), ctx, flags, exp_f);
    end
  endtask

  // one operation: drive at the falling edge, check after the next rising edge
  task automatic step(input logic v, input logic [2:0] c, input logic [1:0] s,
      input logic [31:0] a, b, input logic [31:0] r_other, input logic cwe,
      input logic [2:0] cwd, input string ctx);
    logic [31:0] r;
    logic [2:0]  cv;
    @(negedge clk);
    if (c == 3'd0)      r = a + b;
    else if (c == 3'd1) r = a - b;
    else                r = r_other;
    cv = (c <= 3'd1) ? lane_carries(c, a, b) : 3'($urandom);
    in_valid = v; op_class = c; op_size = s; opnd_a = a; opnd_b = b;
    result = r; carry_out = cv; ctl_we = cwe; ctl_wdata = cwd;
    exp_f = model(exp_f, v, c, s, a, b, r, cv, cwe, cwd);
    @(posedge clk);
    #5;
    compare(ctx);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #5;
    checks++;   // R1 reset state
    if (flags !== 9'd0 || in_ready !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: flags=%h ready=%b expected=000 0", flags, in_ready);
    end
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    checks++;
    if (in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 ready: actual=%b expected=1", in_ready);
    end

    // R2 R4 R5 byte add wraps to zero with carry and half-carry
    step(1, 3'd0, 2'd0, 32'h0000_00FF, 32'h0000_0001, 0, 0, 0, "R2 R5 add wrap 8-bit");
    // R7 R6 signed overflow on byte add
    step(1, 3'd0, 2'd0, 32'h0000_007F, 32'h0000_0001, 0, 0, 0, "R7 add overflow 8-bit");
    // R2 borrow on 16-bit subtract, R3 parity of ones in low byte
    step(1, 3'd1, 2'd1, 32'h0000_0000, 32'h0000_0001, 0, 0, 0, "R2 sub borrow 16-bit");
    // R7 subtract overflow 32-bit
    step(1, 3'd1, 2'd2, 32'h8000_0000, 32'h0000_0001, 0, 0, 0, "R7 sub overflow 32-bit");
    // R8 logic keeps half-carry, clears carry/overflow
    step(1, 3'd0, 2'd0, 32'h0000_000F, 32'h0000_0001, 0, 0, 0, "R4 half-carry set");
    step(1, 3'd2, 2'd2, 0, 0, 32'h0000_0007, 0, 0, "R8 logic odd parity");
    // R5 upper bits ignored at byte size
    step(1, 3'd2, 2'd0, 0, 0, 32'hABCD_0000, 0, 0, "R5 zero upper ignored");
    // R12 size code 3 as 32-bit
    step(1, 3'd0, 2'd3, 32'h7FFF_FFFF, 32'h0000_0001, 0, 0, 0, "R12 size 3 add");
    // R9 move and control leave flags
    step(1, 3'd3, 2'd0, 32'h1, 32'h1, 32'h0, 0, 0, "R9 move hold");
    step(1, 3'd4, 2'd2, 32'h1, 32'h1, 32'hFF, 0, 0, "R9 control hold");
    // R10 control flag write alone and with an operation
    step(0, 3'd0, 2'd0, 0, 0, 0, 1, 3'b101, "R10 control write");
    step(1, 3'd1, 2'd0, 32'h5, 32'h5, 0, 1, 3'b010, "R10 write with op");
    step(1, 3'd0, 2'd1, 32'hFFFF, 32'h1, 0, 0, 0, "R10 op keeps control");
    // R11 idle
    step(0, 3'd0, 2'd0, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, "R11 idle hold");

    for (int n = 0; n < 2000; n++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      if (n % 4 != 3) c = 3'($urandom_range(0, 2));
      step(($urandom_range(0, 9) != 0), c, 2'($urandom), $urandom, $urandom,
           $urandom, ($urandom_range(0, 7) == 0), 3'($urandom),
           "R2 R3 R4 R5 R6 R7 R9 R12 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule